// File: doc/BRIEF.md
# Modulo Timer with Overflow Flag

This block is a free-running counter whose wrap point is set by a modulo input. It forms the time base that a larger timer unit builds on. One of three count sources drives the counter, or the counter is stopped: the bus clock, a fixed-rate tick, or an external clock. A power-of-two prescaler sits after the source selection. The count either runs upward and wraps to zero, or, in center-aligned mode, runs up to the limit and back down.

Software works through one status/control byte. The byte holds the overflow flag, an interrupt enable, the mode select, the source select and the prescale code. The overflow flag cannot be cleared by accident. Software must first read the byte while the flag is set and then write a zero to the flag bit. An overflow that arrives between that read and that write cancels the sequence, so no overflow event is lost.

Top module: `tmr_modulo_timer`

## Requirements
- R1: After reset the status/control byte reads 0x00, the count is 0 and the interrupt request is low.
- R2: The status/control byte is laid out as: bit 7 overflow flag, bit 6 interrupt enable, bit 5 center-aligned select, bits 4:3 source select, bits 2:0 prescale code. A write updates bits 6:0 at the clock edge, and a read returns all eight bits.
- R3: With center-aligned select at 0, each count tick adds one until the count reaches the limit, and the next tick then returns it to 0. The limit is the modulo input, except that a modulo of 0 sets the limit to the all-ones count.
- R4: With center-aligned select at 1, the count rises to the limit and then falls back to 0 one step per tick. At 0 it turns upward again, so it never changes by more than one per tick.
- R5: The overflow flag sets on the tick that wraps the count to 0 in up mode. In center-aligned mode it sets on the tick where the falling count turns upward at 0.
- R6: A read of the byte while the flag is 1, followed later by a write with bit 7 at 0, clears the flag. The flag falls only on such a write.
- R7: A write of 0 to bit 7 leaves the flag set in two cases: no read was made while the flag was 1, or a new overflow happened after that read.
- R8: Writing 1 to bit 7 leaves the flag unchanged.
- R9: The interrupt request is high exactly when both the interrupt enable and the flag are 1.
- R10: Source select 00 holds the count. 01 gives one tick per bus clock cycle. 10 gives one tick per cycle in which the fixed-rate tick input is high.
- R11: Source select 11 counts each rising edge of the external clock once, after a two-flop synchronizer. Falling edges do not count.
- R12: Prescale code k lets every 2^k-th source tick through (k = 0..7). A new code governs the ticks from the cycle after the write onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_clk_i | input | 1 | External count clock, asynchronous |
| fix_tick_i | input | 1 | Fixed-rate tick, one bus cycle wide |
| sc_rd_i | input | 1 | Read strobe of the status/control byte |
| sc_wr_i | input | 1 | Write strobe of the status/control byte |
| sc_wdata_i | input | 8 | Write data |
| sc_rdata_o | output | 8 | Status/control byte |
| modulo_i | input | CNT_W | Modulo limit, 0 selects the full range |
| count_o | output | CNT_W | Current count |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The bench builds the timer with CNT_W = 6, so the count range is 0 to 63. This makes it cheap to sweep every modulo value, including 0, through a full up-mode wrap and a full up/down period, with the count and flag compared each cycle. All eight prescale codes are swept against the full range. The fixed-rate tick is driven by hand, which places overflows exactly before, between or after the read and write of the clearing handshake.

// File: rtl/tmr_pkg.sv
// Shared types for the modulo timer.
// Assumes: the status/control byte has a fixed 8-bit layout that software decodes.
package tmr_pkg;

    localparam int PS_W = 3;   // width of the prescale code

    typedef enum logic [1:0] {
        SRC_OFF = 2'b00,
        SRC_BUS = 2'b01,
        SRC_FIX = 2'b10,
        SRC_EXT = 2'b11
    } src_sel_e;

    typedef struct packed {
        logic            flag;
        logic            ie;
        logic            cpwm;
        src_sel_e        src;
        logic [PS_W-1:0] ps;
    } sc_byte_t;

endpackage

// File: rtl/tmr_src_sel.sv
// Count source selection.
// Produces a single-cycle tick from the bus clock, the fixed-rate tick or
// rising edges of the synchronized external clock.
// Assumes: fix_tick_i is already synchronous to clk; SYNC_STAGES >= 2.
module tmr_src_sel
    import tmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  src_sel_e src_i,
    input  logic     fix_tick_i,
    input  logic     ext_clk_i,
    output logic     tick_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic                   ext_rise;

    // Synchronizer chain and edge-history flop for the external clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], ext_clk_i};
            last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // Rising edge of the synchronized external clock.
    always_comb ext_rise = sync_q[SYNC_STAGES-1] & ~last_q;

    // Source multiplexer.
    always_comb begin
        unique case (src_i)
            SRC_OFF: tick_o = 1'b0;
            SRC_BUS: tick_o = 1'b1;
            SRC_FIX: tick_o = fix_tick_i;
            SRC_EXT: tick_o = ext_rise;
            default: tick_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/tmr_prescaler.sv
// Power-of-two prescaler placed after source selection.
// Passes every 2^ps-th input tick. Its phase counter runs freely, so a new
// code applies on the next cycle with no restart.
// Assumes: ps_i is held in a register.
module tmr_prescaler #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic [PS_W-1:0] ps_i,
    output logic            tick_o
);

    localparam int DIV_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] phase_q;
    logic [DIV_W-1:0] mask;

    // Phase counter advances on each source tick.
    always_ff @(posedge clk) begin
        if (!rst_n)      phase_q <= '0;
        else if (tick_i) phase_q <= phase_q + 1'b1;
    end

    // Low ps_i bits of the mask are set; one bit per possible code.
    always_comb begin
        for (int i = 0; i < DIV_W; i++) begin
            mask[i] = (i < int'(ps_i));
        end
    end

    // Pass the tick when all masked phase bits are ones.
    always_comb tick_o = tick_i && ((phase_q & mask) == mask);

endmodule

// File: rtl/tmr_counter.sv
// Modulo counter with up-only and up/down modes.
// Emits wrap_o on the tick that produces an overflow event.
// Assumes: a modulo of zero stands for the all-ones limit.
module tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             updown_i,
    input  logic [CNT_W-1:0] modulo_i,
    output logic [CNT_W-1:0] count_o,
    output logic             wrap_o
);

    logic [CNT_W-1:0] cnt_q, cnt_d, limit;
    logic             up_q, up_d, wrap_c;

    // Effective limit.
    always_comb limit = (modulo_i == '0) ? '1 : modulo_i;

    // Next-count and direction logic.
    always_comb begin
        cnt_d  = cnt_q;
        up_d   = up_q;
        wrap_c = 1'b0;
        if (!updown_i) begin
            up_d = 1'b1;
            if (cnt_q >= limit) begin
                cnt_d  = '0;
                wrap_c = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end else if (up_q) begin
            if (cnt_q >= limit) begin
                cnt_d = cnt_q - 1'b1;
                up_d  = 1'b0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end else begin
            if (cnt_q == '0) begin
                cnt_d  = CNT_W'(1);
                up_d   = 1'b1;
                wrap_c = 1'b1;
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
        end
    end

    // Count and direction registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            up_q  <= 1'b1;
        end else if (tick_i) begin
            cnt_q <= cnt_d;
            up_q  <= up_d;
        end else if (!updown_i) begin
            up_q  <= 1'b1;
        end
    end

    always_comb count_o = cnt_q;
    always_comb wrap_o  = tick_i && wrap_c;

endmodule

// File: rtl/tmr_ovf_flag.sv
// Overflow flag with the read-then-write-zero clearing handshake.
// A read while the flag is set arms the clear. A later write with a zero
// flag bit clears the flag if still armed. An overflow sets the flag and
// disarms, and it takes precedence over a clear in the same cycle.
// Assumes: rd_i and wr_i are single-cycle bus strobes.
module tmr_ovf_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wr_flag_i,
    output logic flag_o
);

    logic flag_q, armed_q;

    // Flag and handshake-arm state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (wrap_i) begin
            flag_q  <= 1'b1;
            armed_q <= 1'b0;
        end else begin
            if (rd_i && flag_q) armed_q <= 1'b1;
            if (wr_i && !wr_flag_i && armed_q) begin
                flag_q  <= 1'b0;
                armed_q <= 1'b0;
            end
        end
    end

    always_comb flag_o = flag_q;

endmodule

// File: rtl/tmr_modulo_timer.sv
// Top of the modulo timer.
// Holds the control fields of the status/control byte and chains source
// selection, prescaler and counter. Drives the flag and the interrupt request.
// Assumes: a single bus register; strobes are one cycle wide.
module tmr_modulo_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_clk_i,
    input  logic             fix_tick_i,
    input  logic             sc_rd_i,
    input  logic             sc_wr_i,
    input  logic [7:0]       sc_wdata_i,
    output logic [7:0]       sc_rdata_o,
    input  logic [CNT_W-1:0] modulo_i,
    output logic [CNT_W-1:0] count_o,
    output logic             irq_o
);

    sc_byte_t        wr_view;
    logic            ie_q, cpwm_q;
    src_sel_e        src_q;
    logic [PS_W-1:0] ps_q;
    logic            src_tick, cnt_tick, wrap, flag;
    sc_byte_t        rd_view;

    // Decode the written byte into its fields.
    always_comb wr_view = sc_byte_t'(sc_wdata_i);

    // Control field register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q   <= 1'b0;
            cpwm_q <= 1'b0;
            src_q  <= SRC_OFF;
            ps_q   <= '0;
        end else if (sc_wr_i) begin
            ie_q   <= wr_view.ie;
            cpwm_q <= wr_view.cpwm;
            src_q  <= wr_view.src;
            ps_q   <= wr_view.ps;
        end
    end

    tmr_src_sel #(.SYNC_STAGES(SYNC_STAGES)) u_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (src_q),
        .fix_tick_i (fix_tick_i),
        .ext_clk_i  (ext_clk_i),
        .tick_o     (src_tick)
    );

    tmr_prescaler #(.PS_W(PS_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (src_tick),
        .ps_i   (ps_q),
        .tick_o (cnt_tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (cnt_tick),
        .updown_i (cpwm_q),
        .modulo_i (modulo_i),
        .count_o  (count_o),
        .wrap_o   (wrap)
    );

    tmr_ovf_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .wrap_i    (wrap),
        .rd_i      (sc_rd_i),
        .wr_i      (sc_wr_i),
        .wr_flag_i (wr_view.flag),
        .flag_o    (flag)
    );

    // Assemble the readable byte.
    always_comb begin
        rd_view.flag = flag;
        rd_view.ie   = ie_q;
        rd_view.cpwm = cpwm_q;
        rd_view.src  = src_q;
        rd_view.ps   = ps_q;
    end

    always_comb sc_rdata_o = rd_view;
    always_comb irq_o      = ie_q & flag;

endmodule

// File: rtl/tmr_modulo_timer_chk.sv
// Property checker for the modulo timer, bound to its top.
// Assumes: it sees only ports of the top module.
module tmr_modulo_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sc_wr_i,
    input logic             wr_flag_i,
    input logic             flag_i,
    input logic             ie_i,
    input logic             cpwm_i,
    input logic [1:0]       src_i,
    input logic [CNT_W-1:0] count_o,
    input logic             irq_o
);

    AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i == 2'b00) |=> $stable(count_o)); // R10

    AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cpwm_i) && $past(count_o) != '0 && count_o == '0) |-> flag_i); // R5

    AST_UPDOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cpwm_i) |-> (count_o == $past(count_o) || count_o == $past(count_o) + 1'b1 || count_o == $past(count_o) - 1'b1)); // R4

    AST_ONE_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_wr_i && wr_flag_i && flag_i) |=> flag_i); // R8

    AST_FLAG_FALLS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_i) |-> $past(sc_wr_i && !wr_flag_i)); // R6

    AST_IRQ_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (flag_i && ie_i)); // R9

endmodule

bind tmr_modulo_timer tmr_modulo_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sc_wr_i   (sc_wr_i),
    .wr_flag_i (sc_wdata_i[7]),
    .flag_i    (sc_rdata_o[7]),
    .ie_i      (sc_rdata_o[6]),
    .cpwm_i    (sc_rdata_o[5]),
    .src_i     (sc_rdata_o[4:3]),
    .count_o   (count_o),
    .irq_o     (irq_o)
);

// File: tb/tb_tmr_modulo_timer.sv
module tb_tmr_modulo_timer;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 6;
    localparam int MAXV       = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ext_clk_i = 1'b0;
    logic             fix_tick_i = 1'b0;
    logic             sc_rd_i = 1'b0;
    logic             sc_wr_i = 1'b0;
    logic [7:0]       sc_wdata_i = '0;
    logic [7:0]       sc_rdata_o;
    logic [CNT_W-1:0] modulo_i = '0;
    logic [CNT_W-1:0] count_o;
    logic             irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_modulo_timer #(.CNT_W(CNT_W)) dut (.*);

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(logic [7:0] d);
        sc_wdata_i = d;
        sc_wr_i    = 1'b1;
        @(negedge clk);
        sc_wr_i    = 1'b0;
    endtask

    task automatic rd();
        sc_rd_i = 1'b1;
        @(negedge clk);
        sc_rd_i = 1'b0;
    endtask

    task automatic pulse();
        fix_tick_i = 1'b1;
        @(negedge clk);
        fix_tick_i = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int lim, p, expv, c0;
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk("R1", sc_rdata_o, 0);
        chk("R1", count_o, 0);
        chk("R1", irq_o, 0);

        // R3/R5 up-mode sweep of every modulo value
        for (int m = 0; m <= MAXV; m++) begin
            modulo_i = CNT_W'(m);
            do_reset();
            lim = (m == 0) ? MAXV : m;
            wr(8'h08);
            for (int t = 1; t <= lim + 2; t++) begin
                @(negedge clk);
                chk("R3", count_o, t % (lim + 1));
                chk("R5", sc_rdata_o[7], (t >= lim + 1) ? 1 : 0);
            end
        end

        // R4/R5 up/down sweep, R2 readback
        for (int m = 0; m <= MAXV; m++) begin
            modulo_i = CNT_W'(m);
            do_reset();
            lim = (m == 0) ? MAXV : m;
            wr(8'h28);
            for (int t = 1; t <= 2 * lim + 2; t++) begin
                @(negedge clk);
                p = t % (2 * lim);
                expv = (p <= lim) ? p : 2 * lim - p;
                chk("R4", count_o, expv);
                chk("R5", sc_rdata_o[7], (t >= 2 * lim + 1) ? 1 : 0);
                if (t == 1) chk("R2", sc_rdata_o, 8'h28);
            end
        end

        // R12 prescale codes over the full range
        modulo_i = '0;
        for (int ps = 0; ps < 8; ps++) begin
            do_reset();
            wr(8'(8'h08 | ps));
            chk("R2", sc_rdata_o, 8'h08 | ps);
            for (int t = 1; t <= 300; t++) begin
                @(negedge clk);
                chk("R12", count_o, (t >> ps) % (MAXV + 1));
            end
        end

        // R12 code change applies from the next cycle
        do_reset();
        wr(8'h08);
        repeat (4) @(negedge clk);
        wr(8'h09);
        chk("R12", count_o, 5);
        @(negedge clk);
        chk("R12", count_o, 6);
        repeat (19) @(negedge clk);
        chk("R12", count_o, 15);

        // R10 source off holds the count
        do_reset();
        wr(8'h00);
        repeat (20) @(negedge clk);
        chk("R10", count_o, 0);
        wr(8'h08);
        repeat (5) @(negedge clk);
        wr(8'h00);
        chk("R10", count_o, 6);
        repeat (10) @(negedge clk);
        chk("R10", count_o, 6);

        // R10 fixed-rate tick
        do_reset();
        wr(8'h10);
        c0 = 0;
        for (int i = 0; i < 30; i++) begin
            fix_tick_i = (i % 3 == 0);
            @(negedge clk);
            if (i % 3 == 0) c0++;
            chk("R10", count_o, c0);
        end
        fix_tick_i = 1'b0;

        // R11 external clock, rising edges only
        do_reset();
        wr(8'h18);
        for (int k = 0; k < 8; k++) begin
            ext_clk_i = 1'b1;
            repeat (5) @(negedge clk);
            chk("R11", count_o, k + 1);
            ext_clk_i = 1'b0;
            repeat (5) @(negedge clk);
            chk("R11", count_o, k + 1);
        end

        // Flag handshake with modulo 1 and hand-driven ticks
        modulo_i = CNT_W'(1);
        do_reset();
        wr(8'h10);
        pulse(); pulse();
        chk("R5", sc_rdata_o[7], 1);
        wr(8'h90);
        chk("R8", sc_rdata_o, 8'h90);
        wr(8'h10);
        chk("R7", sc_rdata_o[7], 1);       // no prior read
        rd();
        wr(8'h10);
        chk("R6", sc_rdata_o[7], 0);
        chk("R9", irq_o, 0);
        pulse(); pulse();
        rd();
        pulse(); pulse();                   // overflow inside handshake
        wr(8'h10);
        chk("R7", sc_rdata_o[7], 1);
        rd();
        wr(8'h10);
        chk("R6", sc_rdata_o[7], 0);
        rd();                               // read while flag is 0
        pulse(); pulse();
        wr(8'h10);
        chk("R7", sc_rdata_o[7], 1);
        wr(8'h50);
        chk("R9", irq_o, 1);
        rd();
        wr(8'h50);
        chk("R9", irq_o, 0);
        chk("R6", sc_rdata_o[7], 0);
        wr(8'h10);
        pulse(); pulse();
        chk("R9", irq_o, 0);
        chk("R5", sc_rdata_o[7], 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule